// File: doc/BRIEF.md
# Debug Register Access Trap Arbiter

This block decides what happens when software reads or writes one of the watchpoint control registers through the coprocessor register interface. The caller presents the instruction's encoding fields, the current privilege level and a snapshot of the debug trap configuration of the higher levels. The block then names a single outcome: the instruction is undefined, it traps to level 2 (in the 64-bit or the 32-bit hypervisor style), it traps to level 3, it halts into external debug, or the register access goes ahead.

Outcomes come from a fixed priority chain. The chain first checks the register index, then the privilege level, and then the trap controls of each higher level, in a set order for each level the access can come from. The result is registered and appears one cycle after a valid strobe, along with the register index and the exception syndrome code that a trap handler needs. The register file is not part of this block. A neighbouring unit uses the outcome to either perform the access or raise the exception.

Top module: `dbg_acc_arbiter`

## Requirements
- R1: An access belongs to this block only if coprocessor = 4'b1110, opc1 = 3'b000, CRn = 4'b0000 and opc2 = 3'b111. A strobe carrying any other encoding produces no response: res_vld and every outcome stay low in the following cycle.
- R2: A strobe for a matching encoding produces res_vld in the next cycle with exactly one outcome output high. In any cycle that does not follow such a strobe, res_vld and all outcome outputs are low.
- R3: A register index (CRm[3:0]) at or above NUM_WP gives undefined, whatever the privilege level and the trap controls.
- R4: Any in-range access from privilege level 0 gives undefined.
- R5: At level 1 or 2, if level 3 is present and 64-bit, its debug trap bit is set and the early-undefined flag is set, the result is undefined. At level 1 this takes priority over the level-2 trap.
- R6: At level 1, if level 2 is enabled and either of its two trap bits is set, the access traps to level 2. The trap is 64-bit style (res_trap_l2) when level 2 is 64-bit and hypervisor style (res_trap_hyp) when level 2 is 32-bit.
- R7: At level 1 or 2, when no earlier rule applies and level 3 is present, 64-bit and has its debug trap bit set, the access traps to level 3. If the late-undefined flag is set, the result is undefined instead.
- R8: At level 2 the level-2 trap bits and the level-2 width have no effect on the outcome.
- R9: A debug halt results when the OS lock is clear, halting is allowed and the external debug trap bit is set, and no earlier rule applies. At level 3 the only possible outcomes for an in-range index are halt and access.
- R10: res_syndrome is 6'h05 with each of the three trap outcomes and 0 otherwise. res_index repeats CRm of the access it answers.
- R11: An in-range access from level 1, 2 or 3 that meets none of the conditions above is performed (res_access).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Access strobe, one cycle per access |
| req_coproc | input | 4 | Coprocessor number field |
| req_opc1 | input | 3 | First opcode field |
| req_crn | input | 4 | CRn field |
| req_crm | input | 4 | CRm field, register index |
| req_opc2 | input | 3 | Second opcode field |
| cur_lvl | input | 2 | Current privilege level 0..3 |
| l2_en | input | 1 | Level 2 enabled |
| l2_narrow | input | 1 | Level 2 runs in 32-bit mode |
| l3_here | input | 1 | Level 3 present |
| l3_narrow | input | 1 | Level 3 runs in 32-bit mode |
| l2_trap_all | input | 1 | Level-2 trap-everything-debug bit |
| l2_trap_dbg | input | 1 | Level-2 debug register trap bit |
| l3_trap_dbg | input | 1 | Level-3 debug register trap bit |
| l3_undef_early | input | 1 | Undefined takes priority over level-2 trap |
| l3_undef_late | input | 1 | Level-3 trap becomes undefined |
| os_lock | input | 1 | OS lock set |
| halt_ok | input | 1 | Halting allowed |
| ext_trap_dbg | input | 1 | External debugger trap bit |
| res_vld | output | 1 | Result valid |
| res_undef | output | 1 | Outcome: undefined instruction |
| res_trap_l2 | output | 1 | Outcome: 64-bit style trap to level 2 |
| res_trap_hyp | output | 1 | Outcome: 32-bit hypervisor trap |
| res_trap_l3 | output | 1 | Outcome: trap to level 3 |
| res_halt | output | 1 | Outcome: debug halt |
| res_access | output | 1 | Outcome: perform the access |
| res_index | output | 4 | Register index of the answered access |
| res_syndrome | output | 6 | Syndrome code for trap outcomes |

## Verification
The hardest cases to reach are the ones where a lower-priority condition is active but has to stay hidden. Examples are a level-2 trap that must lose to the early-undefined rule, a level-3 trap that the late flag must turn into undefined, and a level-2 trap configuration that must be ignored at level 2. The stimulus reaches each of these by turning on every condition below the expected winner along with the winner itself, so a wrong priority order shows up as the wrong outcome bit. Back-to-back strobes with different outcomes check that each result belongs to its own access.

// File: rtl/dbg_acc_pkg.sv
package dbg_acc_pkg;

  localparam int unsigned IDX_W  = 4;
  localparam int unsigned LVL_W  = 2;
  localparam int unsigned NUM_LVL = 1 << LVL_W;
  localparam int unsigned SYN_W  = 6;
  localparam logic [SYN_W-1:0] SYN_DBG_ACC = 6'h05;

  localparam logic [3:0] ENC_COPROC = 4'b1110;
  localparam logic [2:0] ENC_OPC1   = 3'b000;
  localparam logic [3:0] ENC_CRN    = 4'b0000;
  localparam logic [2:0] ENC_OPC2   = 3'b111;

  typedef enum logic [2:0] {
    OC_NONE     = 3'd0,
    OC_UNDEF    = 3'd1,
    OC_TRAP_L2  = 3'd2,
    OC_TRAP_HYP = 3'd3,
    OC_TRAP_L3  = 3'd4,
    OC_HALT     = 3'd5,
    OC_ACCESS   = 3'd6
  } outcome_e;

  typedef struct packed {
    logic l2_en;
    logic l2_narrow;
    logic l3_here;
    logic l3_narrow;
    logic l2_trap_all;
    logic l2_trap_dbg;
    logic l3_trap_dbg;
    logic l3_undef_early;
    logic l3_undef_late;
    logic os_lock;
    logic halt_ok;
    logic ext_trap_dbg;
  } ctl_t;

endpackage

// File: rtl/dbg_acc_decode.sv
module dbg_acc_decode
  import dbg_acc_pkg::*;
#(
  parameter int unsigned NUM_WP = 12
) (
  input  logic [3:0]       coproc,
  input  logic [2:0]       opc1,
  input  logic [3:0]       crn,
  input  logic [IDX_W-1:0] crm,
  input  logic [2:0]       opc2,
  output logic             enc_hit,
  output logic             idx_ok
);

  localparam int unsigned CMP_W = IDX_W + 1;
  localparam logic [CMP_W-1:0] WP_LIMIT = CMP_W'(NUM_WP);

  logic [CMP_W-1:0] idx_ext;

  always_comb begin
    enc_hit = (coproc == ENC_COPROC) && (opc1 == ENC_OPC1) &&
              (crn == ENC_CRN) && (opc2 == ENC_OPC2);
    idx_ext = {1'b0, crm};
    idx_ok  = (idx_ext < WP_LIMIT);
  end

endmodule

// File: rtl/dbg_acc_chain.sv
module dbg_acc_chain
  import dbg_acc_pkg::*;
(
  input  logic [LVL_W-1:0] lvl,
  input  logic             idx_ok,
  input  ctl_t             ctl,
  output outcome_e         oc
);

  logic l3_route;
  logic l3_early;
  logic l2_route;
  logic halt_hit;

  outcome_e lvl_oc [NUM_LVL];

  always_comb begin
    l3_route = ctl.l3_here && !ctl.l3_narrow && ctl.l3_trap_dbg;
    l3_early = l3_route && ctl.l3_undef_early;
    l2_route = ctl.l2_en && (ctl.l2_trap_all || ctl.l2_trap_dbg);
    halt_hit = !ctl.os_lock && ctl.halt_ok && ctl.ext_trap_dbg;
  end

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    if (g == 0) begin : g_user
      assign lvl_oc[g] = OC_UNDEF;
    end else if (g == NUM_LVL - 1) begin : g_top
      assign lvl_oc[g] = halt_hit ? OC_HALT : OC_ACCESS;
    end else begin : g_mid
      always_comb begin
        if (l3_early) begin
          lvl_oc[g] = OC_UNDEF;
        end else if ((g == 1) && l2_route && !ctl.l2_narrow) begin
          lvl_oc[g] = OC_TRAP_L2;
        end else if ((g == 1) && l2_route && ctl.l2_narrow) begin
          lvl_oc[g] = OC_TRAP_HYP;
        end else if (l3_route) begin
          lvl_oc[g] = ctl.l3_undef_late ? OC_UNDEF : OC_TRAP_L3;
        end else if (halt_hit) begin
          lvl_oc[g] = OC_HALT;
        end else begin
          lvl_oc[g] = OC_ACCESS;
        end
      end
    end
  end

  always_comb begin
    if (!idx_ok) begin
      oc = OC_UNDEF;
    end else begin
      oc = lvl_oc[lvl];
    end
  end

endmodule

// File: rtl/dbg_acc_resreg.sv
module dbg_acc_resreg
  import dbg_acc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  outcome_e         oc_in,
  input  logic [IDX_W-1:0] idx_in,
  output logic             res_vld,
  output logic             res_undef,
  output logic             res_trap_l2,
  output logic             res_trap_hyp,
  output logic             res_trap_l3,
  output logic             res_halt,
  output logic             res_access,
  output logic [IDX_W-1:0] res_index,
  output logic [SYN_W-1:0] res_syndrome
);

  outcome_e         oc_q, oc_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             upd_en;

  always_comb begin
    upd_en = take || (oc_q != OC_NONE);
    oc_d   = take ? oc_in  : OC_NONE;
    idx_d  = take ? idx_in : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_q  <= OC_NONE;
      idx_q <= '0;
    end else if (upd_en) begin
      oc_q  <= oc_d;
      idx_q <= idx_d;
    end
  end

  always_comb begin
    res_vld      = (oc_q != OC_NONE);
    res_undef    = (oc_q == OC_UNDEF);
    res_trap_l2  = (oc_q == OC_TRAP_L2);
    res_trap_hyp = (oc_q == OC_TRAP_HYP);
    res_trap_l3  = (oc_q == OC_TRAP_L3);
    res_halt     = (oc_q == OC_HALT);
    res_access   = (oc_q == OC_ACCESS);
    res_index    = idx_q;
    res_syndrome = (res_trap_l2 || res_trap_hyp || res_trap_l3) ? SYN_DBG_ACC : '0;
  end

endmodule

// File: rtl/dbg_acc_arbiter.sv
module dbg_acc_arbiter
  import dbg_acc_pkg::*;
#(
  parameter int unsigned NUM_WP = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_vld,
  input  logic [3:0] req_coproc,
  input  logic [2:0] req_opc1,
  input  logic [3:0] req_crn,
  input  logic [3:0] req_crm,
  input  logic [2:0] req_opc2,
  input  logic [1:0] cur_lvl,
  input  logic       l2_en,
  input  logic       l2_narrow,
  input  logic       l3_here,
  input  logic       l3_narrow,
  input  logic       l2_trap_all,
  input  logic       l2_trap_dbg,
  input  logic       l3_trap_dbg,
  input  logic       l3_undef_early,
  input  logic       l3_undef_late,
  input  logic       os_lock,
  input  logic       halt_ok,
  input  logic       ext_trap_dbg,
  output logic       res_vld,
  output logic       res_undef,
  output logic       res_trap_l2,
  output logic       res_trap_hyp,
  output logic       res_trap_l3,
  output logic       res_halt,
  output logic       res_access,
  output logic [3:0] res_index,
  output logic [5:0] res_syndrome
);

  logic     enc_hit;
  logic     idx_ok;
  logic     take;
  ctl_t     ctl;
  outcome_e oc;

  always_comb begin
    ctl.l2_en          = l2_en;
    ctl.l2_narrow      = l2_narrow;
    ctl.l3_here        = l3_here;
    ctl.l3_narrow      = l3_narrow;
    ctl.l2_trap_all    = l2_trap_all;
    ctl.l2_trap_dbg    = l2_trap_dbg;
    ctl.l3_trap_dbg    = l3_trap_dbg;
    ctl.l3_undef_early = l3_undef_early;
    ctl.l3_undef_late  = l3_undef_late;
    ctl.os_lock        = os_lock;
    ctl.halt_ok        = halt_ok;
    ctl.ext_trap_dbg   = ext_trap_dbg;
    take               = req_vld && enc_hit;
  end

  dbg_acc_decode #(.NUM_WP(NUM_WP)) u_decode (
    .coproc  (req_coproc),
    .opc1    (req_opc1),
    .crn     (req_crn),
    .crm     (req_crm),
    .opc2    (req_opc2),
    .enc_hit (enc_hit),
    .idx_ok  (idx_ok)
  );

  dbg_acc_chain u_chain (
    .lvl    (cur_lvl),
    .idx_ok (idx_ok),
    .ctl    (ctl),
    .oc     (oc)
  );

  dbg_acc_resreg u_resreg (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (take),
    .oc_in        (oc),
    .idx_in       (req_crm),
    .res_vld      (res_vld),
    .res_undef    (res_undef),
    .res_trap_l2  (res_trap_l2),
    .res_trap_hyp (res_trap_hyp),
    .res_trap_l3  (res_trap_l3),
    .res_halt     (res_halt),
    .res_access   (res_access),
    .res_index    (res_index),
    .res_syndrome (res_syndrome)
  );

  logic [5:0] oc_vec;
  assign oc_vec = {res_undef, res_trap_l2, res_trap_hyp, res_trap_l3, res_halt, res_access};

  AST_NO_FOREIGN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !enc_hit) |=> !res_vld) else $error("foreign encoding answered"); // R1

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (res_vld && ($countones(oc_vec) == 1))) else $error("outcome count wrong"); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (!res_vld && (oc_vec == '0))) else $error("result without strobe"); // R2

  AST_IDX_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !idx_ok) |=> res_undef) else $error("out-of-range index not undefined"); // R3

  AST_LVL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (cur_lvl == 2'd0)) |=> res_undef) else $error("level 0 not undefined"); // R4

  AST_LVL3_LIMITED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && idx_ok && (cur_lvl == 2'd3)) |=> (res_halt || res_access))
    else $error("level 3 outcome outside halt or access"); // R9

  AST_TRAP_SYNDROME: assert property (@(posedge clk) disable iff (!rst_n)
    (res_trap_l2 || res_trap_hyp || res_trap_l3) |-> (res_syndrome == 6'h05))
    else $error("trap without syndrome"); // R10

  AST_INDEX_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (res_index == $past(req_crm))) else $error("index not echoed"); // R10

endmodule

// File: tb/dbg_acc_arbiter_bench.sv
`timescale 1ns/1ps
module dbg_acc_arbiter_bench;

  localparam int NUM_WP = 12;

  localparam logic [5:0] E_UNDEF = 6'b100000;
  localparam logic [5:0] E_TL2   = 6'b010000;
  localparam logic [5:0] E_HYP   = 6'b001000;
  localparam logic [5:0] E_TL3   = 6'b000100;
  localparam logic [5:0] E_HALT  = 6'b000010;
  localparam logic [5:0] E_ACC   = 6'b000001;
  localparam logic [5:0] E_NONE  = 6'b000000;

  logic clk = 1'b0;
  logic rst_n;
  logic req_vld;
  logic [3:0] req_coproc, req_crn, req_crm;
  logic [2:0] req_opc1, req_opc2;
  logic [1:0] cur_lvl;
  logic l2_en, l2_narrow, l3_here, l3_narrow, l2_trap_all, l2_trap_dbg, l3_trap_dbg;
  logic l3_undef_early, l3_undef_late, os_lock, halt_ok, ext_trap_dbg;
  logic res_vld, res_undef, res_trap_l2, res_trap_hyp, res_trap_l3, res_halt, res_access;
  logic [3:0] res_index;
  logic [5:0] res_syndrome;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dbg_acc_arbiter #(.NUM_WP(NUM_WP)) u_dbg_acc_arbiter (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld),
    .req_coproc(req_coproc), .req_opc1(req_opc1), .req_crn(req_crn),
    .req_crm(req_crm), .req_opc2(req_opc2), .cur_lvl(cur_lvl),
    .l2_en(l2_en), .l2_narrow(l2_narrow), .l3_here(l3_here), .l3_narrow(l3_narrow),
    .l2_trap_all(l2_trap_all), .l2_trap_dbg(l2_trap_dbg), .l3_trap_dbg(l3_trap_dbg),
    .l3_undef_early(l3_undef_early), .l3_undef_late(l3_undef_late),
    .os_lock(os_lock), .halt_ok(halt_ok), .ext_trap_dbg(ext_trap_dbg),
    .res_vld(res_vld), .res_undef(res_undef), .res_trap_l2(res_trap_l2),
    .res_trap_hyp(res_trap_hyp), .res_trap_l3(res_trap_l3), .res_halt(res_halt),
    .res_access(res_access), .res_index(res_index), .res_syndrome(res_syndrome)
  );

  task automatic clear_all();
    req_vld = 0; req_coproc = 4'b1110; req_opc1 = 3'b000; req_crn = 4'b0000;
    req_opc2 = 3'b111; req_crm = 4'd0; cur_lvl = 2'd1;
    l2_en = 0; l2_narrow = 0; l3_here = 0; l3_narrow = 0; l2_trap_all = 0;
    l2_trap_dbg = 0; l3_trap_dbg = 0; l3_undef_early = 0; l3_undef_late = 0;
    os_lock = 0; halt_ok = 0; ext_trap_dbg = 0;
  endtask

  task automatic check(input logic [5:0] exp_oc, input logic exp_vld,
                       input logic [3:0] exp_idx, input string tag);
    logic [5:0] act;
    logic [5:0] exp_syn;
    act = {res_undef, res_trap_l2, res_trap_hyp, res_trap_l3, res_halt, res_access};
    exp_syn = (exp_oc == E_TL2 || exp_oc == E_HYP || exp_oc == E_TL3) ? 6'h05 : 6'h00;
    n_chk++;
    if (act !== exp_oc || res_vld !== exp_vld) begin
      n_fail++;
      $display("FAIL %s outcome: actual vld=%b oc=%b expected vld=%b oc=%b",
               tag, res_vld, act, exp_vld, exp_oc);
    end
    if (exp_vld) begin
      n_chk++;
      if (res_syndrome !== exp_syn || res_index !== exp_idx) begin
        n_fail++;
        $display("FAIL R10 (%s) syndrome/index: actual %h/%0d expected %h/%0d",
                 tag, res_syndrome, res_index, exp_syn, exp_idx);
      end
    end
  endtask

  // One strobe at a falling edge, result sampled at the next falling edge.
  task automatic access(input logic [5:0] exp_oc, input string tag);
    logic [3:0] idx;
    idx = req_crm;
    req_vld = 1;
    @(negedge clk);
    req_vld = 0;
    check(exp_oc, 1'b1, idx, tag);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(E_NONE, 1'b0, 4'd0, "R2 reset");
  endtask

  task automatic t_encoding();
    clear_all(); cur_lvl = 2'd3; req_coproc = 4'b1111;
    req_vld = 1; @(negedge clk); req_vld = 0;
    check(E_NONE, 1'b0, 4'd0, "R1 wrong coproc");
    clear_all(); cur_lvl = 2'd3; req_opc2 = 3'b110;
    req_vld = 1; @(negedge clk); req_vld = 0;
    check(E_NONE, 1'b0, 4'd0, "R1 wrong opc2");
    clear_all(); cur_lvl = 2'd3; req_crn = 4'b0001;
    req_vld = 1; @(negedge clk); req_vld = 0;
    check(E_NONE, 1'b0, 4'd0, "R1 wrong crn");
    clear_all(); cur_lvl = 2'd3; req_crm = 4'd5;
    access(E_ACC, "R1 matching encoding");
  endtask

  task automatic t_index();
    clear_all(); cur_lvl = 2'd3; req_crm = 4'd12;
    access(E_UNDEF, "R3 index at limit");
    clear_all(); cur_lvl = 2'd3; req_crm = 4'd15; halt_ok = 1; ext_trap_dbg = 1;
    access(E_UNDEF, "R3 index max beats halt");
    clear_all(); cur_lvl = 2'd1; req_crm = 4'd11;
    access(E_ACC, "R3 last valid index");
  endtask

  task automatic t_lvl0();
    clear_all(); cur_lvl = 2'd0; req_crm = 4'd2;
    access(E_UNDEF, "R4 level 0");
    clear_all(); cur_lvl = 2'd0; halt_ok = 1; ext_trap_dbg = 1; l2_en = 1; l2_trap_dbg = 1;
    access(E_UNDEF, "R4 level 0 with traps");
  endtask

  task automatic t_lvl1();
    clear_all(); req_crm = 4'd3; l3_here = 1; l3_trap_dbg = 1; l3_undef_early = 1;
    l2_en = 1; l2_trap_dbg = 1; halt_ok = 1; ext_trap_dbg = 1;
    access(E_UNDEF, "R5 early undefined over level-2 trap");
    clear_all(); l2_en = 1; l2_trap_all = 1; l3_here = 1; l3_trap_dbg = 1;
    halt_ok = 1; ext_trap_dbg = 1;
    access(E_TL2, "R6 64-bit level-2 trap");
    clear_all(); l2_en = 1; l2_narrow = 1; l2_trap_dbg = 1; l3_here = 1; l3_trap_dbg = 1;
    access(E_HYP, "R6 32-bit hypervisor trap");
    clear_all(); l2_en = 0; l2_trap_dbg = 1; l2_trap_all = 1;
    access(E_ACC, "R6 level 2 disabled ignores bits");
    clear_all(); l2_en = 1; l3_here = 1; l3_trap_dbg = 1; halt_ok = 1; ext_trap_dbg = 1;
    access(E_TL3, "R7 level-3 trap at level 1");
    clear_all(); l3_here = 1; l3_trap_dbg = 1; l3_undef_late = 1;
    access(E_UNDEF, "R7 late undefined at level 1");
    clear_all(); l3_here = 1; l3_narrow = 1; l3_trap_dbg = 1; l3_undef_early = 1;
    access(E_ACC, "R7 32-bit level 3 does not trap");
    clear_all(); halt_ok = 1; ext_trap_dbg = 1;
    access(E_HALT, "R9 halt at level 1");
    clear_all(); halt_ok = 1; ext_trap_dbg = 1; os_lock = 1;
    access(E_ACC, "R11 locked so no halt");
  endtask

  task automatic t_lvl2();
    clear_all(); cur_lvl = 2'd2; l2_en = 1; l2_trap_all = 1; l2_trap_dbg = 1;
    access(E_ACC, "R8 level-2 bits ignored at level 2");
    clear_all(); cur_lvl = 2'd2; l2_en = 1; l2_narrow = 1; l2_trap_dbg = 1;
    halt_ok = 1; ext_trap_dbg = 1;
    access(E_HALT, "R8 narrow level 2 ignored at level 2");
    clear_all(); cur_lvl = 2'd2; l2_en = 1; l2_trap_dbg = 1; l3_here = 1; l3_trap_dbg = 1;
    access(E_TL3, "R7 level-3 trap at level 2");
    clear_all(); cur_lvl = 2'd2; l3_here = 1; l3_trap_dbg = 1; l3_undef_early = 1;
    access(E_UNDEF, "R5 early undefined at level 2");
  endtask

  task automatic t_lvl3();
    clear_all(); cur_lvl = 2'd3; l3_here = 1; l3_trap_dbg = 1; l3_undef_early = 1;
    l2_en = 1; l2_trap_all = 1; halt_ok = 1; ext_trap_dbg = 1; req_crm = 4'd9;
    access(E_HALT, "R9 level 3 halt only");
    clear_all(); cur_lvl = 2'd3; l3_here = 1; l3_trap_dbg = 1; l3_undef_late = 1;
    access(E_ACC, "R11 level 3 access");
    clear_all(); cur_lvl = 2'd3; halt_ok = 0; ext_trap_dbg = 1;
    access(E_ACC, "R9 halt not allowed");
  endtask

  task automatic t_strobe();
    clear_all(); cur_lvl = 2'd3; req_crm = 4'd4;
    @(negedge clk);
    check(E_NONE, 1'b0, 4'd0, "R2 no strobe");
    req_vld = 1;
    @(negedge clk);
    check(E_ACC, 1'b1, 4'd4, "R2 back-to-back first");
    cur_lvl = 2'd0; req_crm = 4'd7;
    @(negedge clk);
    req_vld = 0;
    check(E_UNDEF, 1'b1, 4'd7, "R2 back-to-back second");
    @(negedge clk);
    check(E_NONE, 1'b0, 4'd0, "R2 idle after strobes");
  endtask

  initial begin
    clear_all();
    rst_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_encoding();
    t_index();
    t_lvl0();
    t_lvl1();
    t_lvl2();
    t_lvl3();
    t_strobe();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule